// File: doc/BRIEF.md
# Banked Extended UART Register Decoder

This block is the host-facing register file of a 16550-style UART that carries a concealed set of extra registers. The host presents a 3-bit offset with read and write strobes and 8-bit data. A write of 0xBF to the line control register switches the upper offsets from their usual meaning to an extended view. In that view, offset 2 becomes an extended control register. A 2-bit bank field in that register then chooses which of four banks appears at offsets 4 to 7.

The banks hold the software flow-control characters, the FIFO watermark and trigger levels, an enumeration byte and a fixed hardware identifier. Any other line control value restores the usual view, and the extended registers keep their contents. The standard UART datapath is outside this block. In the usual view, only the line control register is stored here. Offset 7 shows the receive path's good-data count when enhanced mode is on. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `uart_bank_regs`

## Requirements
- R1: Offset 3 is the line control register in both views. It is readable and writable in all 8 bits. `ext_view` is high exactly while it holds 0xBF.
- R2: In the extended view, offset 2 is the extended control register, readable and writable in all 8 bits. Its bits 7:6 choose the bank (0 to 3) and its bit 4 enables enhanced mode.
- R3: With bank 0 selected in the extended view, offsets 4, 5, 6 and 7 read and write the XON1, XON2, XOFF1 and XOFF2 characters. These appear on `flow_codes` in bytes 0, 1, 2 and 3.
- R4: With bank 1 selected in the extended view, offsets 4, 5, 6 and 7 read and write the receive low-water mark, receive high-water mark, receive trigger level and transmit threshold. These appear on `fifo_levels` in bytes 0, 1, 2 and 3.
- R5: With bank 2 selected in the extended view, offset 4 reads and writes the enumeration byte, and offset 5 reads the parameter `HW_ID`. A write to offset 5 changes nothing.
- R6: Every other offset reads 0x00, and a write to it changes no register. This covers bank 2 offsets 6 and 7, all of bank 3, extended offsets 0 and 1, usual-view offsets 0, 1, 2, 4, 5 and 6, and usual-view offset 7 when enhanced mode is off.
- R7: Leaving the extended view keeps every extended register. Writes in the usual view to offsets 2 and 4 to 7 leave them unchanged.
- R8: In the usual view with enhanced mode on, offset 7 reads `{gd_bad, gd_count}`, with the bad-data flag in bit 7 and the count in bits 6:0.
- R9: `rdata` is 0x00 whenever `rd_en` is low.
- R10: Reset clears every register, so the usual view is active and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| gd_count | input | 7 | Good-data byte count from the receive path |
| gd_bad | input | 1 | Bad data present in the receive FIFO |
| rdata | output | 8 | Read data, combinational |
| ext_view | output | 1 | Extended view active |
| lcr_q | output | 8 | Line control register |
| ectl_q | output | 8 | Extended control register |
| flow_codes | output | 32 | XOFF2, XOFF1, XON2, XON1 (byte 3 down to 0) |
| fifo_levels | output | 32 | TX threshold, RX trigger, RX high, RX low (byte 3 down to 0) |
| enum_val | output | 8 | Enumeration byte |

## Verification
The assertions check these properties on every cycle:
- the line control write path and the entry into the extended view;
- the bank 0 and bank 1 write paths;
- that usual-view writes leave the extended registers alone;
- the fixed read of the hardware ID;
- the zero read data when no read is strobed;
- the reset state.

Several behaviours are shown only by the bench's scenarios. The bench walks every offset of every bank and reads each one back against its own model, which exposes aliasing between banks. It also shows the survival of contents across leaving and re-entering the extended view, and the good-data-length view under several count and flag patterns.

// File: rtl/uart_bank_regs.sv
module uart_bank_regs #(
  parameter logic [7:0] HW_ID = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  input  logic [6:0]  gd_count,
  input  logic        gd_bad,
  output logic [7:0]  rdata,
  output logic        ext_view,
  output logic [7:0]  lcr_q,
  output logic [7:0]  ectl_q,
  output logic [31:0] flow_codes,
  output logic [31:0] fifo_levels,
  output logic [7:0]  enum_val
);

  localparam logic [7:0] EXT_KEY = 8'hBF;

  logic [7:0] bank_q [8];
  logic [1:0] bank_sel;
  logic       enh_on;
  logic       wr_bank, wr_enum;
  logic [7:0] rmux;

  assign ext_view = (lcr_q == EXT_KEY);
  assign bank_sel = ectl_q[7:6];
  assign enh_on   = ectl_q[4];
  assign wr_bank  = wr_en && ext_view && addr[2] && !bank_sel[1];
  assign wr_enum  = wr_en && ext_view && addr == 3'd4 && bank_sel == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q    <= '0;
      ectl_q   <= '0;
      enum_val <= '0;
      for (int i = 0; i < 8; i++) bank_q[i] <= '0;
    end else begin
      if (wr_en && addr == 3'd3) lcr_q <= wdata;
      if (wr_en && ext_view && addr == 3'd2) ectl_q <= wdata;
      if (wr_bank) bank_q[{bank_sel[0], addr[1:0]}] <= wdata;
      if (wr_enum) enum_val <= wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_out
      assign flow_codes[8*g +: 8]  = bank_q[g];
      assign fifo_levels[8*g +: 8] = bank_q[4+g];
    end
  endgenerate

  always_comb begin
    rmux = '0;
    if (addr == 3'd3) rmux = lcr_q;
    else if (ext_view) begin
      if (addr == 3'd2) rmux = ectl_q;
      else if (addr[2]) begin
        if (!bank_sel[1]) rmux = bank_q[{bank_sel[0], addr[1:0]}];
        else if (bank_sel == 2'd2 && addr == 3'd4) rmux = enum_val;
        else if (bank_sel == 2'd2 && addr == 3'd5) rmux = HW_ID;
      end
    end else if (addr == 3'd7 && enh_on) rmux = {gd_bad, gd_count};
  end

  assign rdata = rd_en ? rmux : 8'h00;

  p_lcr_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && wdata == EXT_KEY) |=> ext_view);

  p_bank0_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ext_view && bank_sel == 2'd0 && addr == 3'd4) |=> flow_codes[7:0] == $past(wdata));

  p_bank1_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ext_view && bank_sel == 2'd1 && addr == 3'd7) |=> fifo_levels[31:24] == $past(wdata));

  p_hwid_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ext_view && bank_sel == 2'd2 && addr == 3'd5) |-> rdata == HW_ID);

  p_keep_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_view) |=> ($stable(flow_codes) && $stable(fifo_levels) && $stable(enum_val) && $stable(ectl_q)));

  p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |-> rdata == 8'h00);

  p_reset_r10: assert property (@(posedge clk)
    (!rst_n) |=> (lcr_q == 8'h00 && ectl_q == 8'h00 && flow_codes == '0 && fifo_levels == '0 && enum_val == 8'h00));

endmodule

// File: tb/uart_bank_regs_tb.sv
module uart_bank_regs_tb;
  localparam logic [7:0] HWID = 8'h5C;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  addr = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  wdata = '0;
  logic [6:0]  gd_count = '0;
  logic        gd_bad = 0;
  logic [7:0]  rdata, lcr_q, ectl_q, enum_val;
  logic        ext_view;
  logic [31:0] flow_codes, fifo_levels;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_lcr = 0, m_ectl = 0, m_enum = 0;
  logic [7:0] m_bank [8] = '{default: 8'h00};

  always #5 clk = ~clk;

  uart_bank_regs #(.HW_ID(HWID)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .gd_count(gd_count), .gd_bad(gd_bad), .rdata(rdata),
    .ext_view(ext_view), .lcr_q(lcr_q), .ectl_q(ectl_q),
    .flow_codes(flow_codes), .fifo_levels(fifo_levels), .enum_val(enum_val)
  );

  function automatic logic [7:0] model_read(input logic [2:0] a);
    logic ext = (m_lcr == 8'hBF);
    logic [1:0] b = m_ectl[7:6];
    if (a == 3) return m_lcr;
    if (ext) begin
      if (a == 2) return m_ectl;
      if (a >= 4 && b < 2) return m_bank[b * 4 + (a - 4)];
      if (a == 4 && b == 2) return m_enum;
      if (a == 5 && b == 2) return HWID;
      return 8'h00;
    end
    if (a == 7 && m_ectl[4]) return {gd_bad, gd_count};
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic ext = (m_lcr == 8'hBF);
    logic [1:0] b = m_ectl[7:6];
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (a == 3) m_lcr = d;
    else if (ext) begin
      if (a == 2) m_ectl = d;
      else if (a >= 4 && b < 2) m_bank[b * 4 + (a - 4)] = d;
      else if (a == 4 && b == 2) m_enum = d;
    end
  endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1;
    #1;
    check(tag, rdata, model_read(a));
    rd_en = 0;
  endtask

  task automatic outs_chk(input string tag);
    #1;
    check(tag, flow_codes, {m_bank[3], m_bank[2], m_bank[1], m_bank[0]});
    check(tag, fifo_levels, {m_bank[7], m_bank[6], m_bank[5], m_bank[4]});
    check(tag, enum_val, m_enum);
    check("R1", ext_view, m_lcr == 8'hBF);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10", {lcr_q, ectl_q, enum_val}, 24'h0);
    outs_chk("R10");
    for (int a = 0; a < 8; a++) rd_chk(a[2:0], "R10");

    // R9: no read strobe, zero data
    @(negedge clk); addr = 3; #1; check("R9", rdata, 8'h00);

    // R6: usual-view writes ignored, R1 lcr round trip
    for (int a = 0; a < 8; a++) if (a != 3) wr(a[2:0], 8'hE0 | a[7:0]);
    wr(3, 8'h1B); rd_chk(3, "R1"); outs_chk("R6");
    for (int a = 0; a < 8; a++) rd_chk(a[2:0], "R6");

    // enter extended view, sweep all banks
    wr(3, 8'hBF); outs_chk("R1");
    for (int b = 0; b < 4; b++) begin
      wr(2, {b[1:0], 6'h10}); rd_chk(2, "R2");
      for (int a = 0; a < 8; a++)
        if (a != 2 && a != 3) wr(a[2:0], 8'h3C ^ {b[1:0], 1'b0, a[2:0], 2'b01});
      outs_chk(b == 0 ? "R3" : b == 1 ? "R4" : b == 2 ? "R5" : "R6");
      for (int a = 0; a < 8; a++)
        rd_chk(a[2:0], b == 0 ? "R3" : b == 1 ? "R4" : b == 2 ? "R5" : "R6");
    end
    // revisit every bank for aliasing
    for (int b = 0; b < 4; b++) begin
      wr(2, {b[1:0], 6'h10});
      for (int a = 4; a < 8; a++) rd_chk(a[2:0], b == 0 ? "R3" : b == 1 ? "R4" : "R5");
    end

    // leave extended view, enhanced on: good-data length
    wr(3, 8'h03); outs_chk("R7");
    for (int k = 0; k < 8; k++) begin
      gd_count = 7'(k * 19); gd_bad = k[0];
      rd_chk(7, "R8");
    end
    // usual-view writes must not disturb extended state
    for (int a = 4; a < 8; a++) wr(a[2:0], 8'hFF);
    wr(2, 8'h00); outs_chk("R7");
    wr(3, 8'hBF); rd_chk(2, "R7");
    for (int b = 0; b < 3; b++) begin
      wr(2, {b[1:0], 6'h00});
      for (int a = 4; a < 8; a++) rd_chk(a[2:0], "R7");
    end
    // enhanced off: offset 7 reads zero in usual view
    wr(3, 8'h00); gd_count = 7'h55; gd_bad = 1;
    rd_chk(7, "R6");

    // reset again clears state
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    m_lcr = 0; m_ectl = 0; m_enum = 0;
    for (int i = 0; i < 8; i++) m_bank[i] = 0;
    outs_chk("R10"); check("R10", lcr_q, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule